// File: doc/BRIEF.md
# Per-Pin Dual-Stage Edge-Selectable Input Synchroniser

This block conditions a bank of general-purpose input pads before their values reach the input register and the interrupt detector. Each pad value passes through two cascaded conditioning stages. The first stage feeds the second, and the output of the second stage is the conditioned value.

Each stage of each pin has its own 2-bit mode. The mode makes the stage transparent, or samples the stage input on the falling edge or on the rising edge of the operating clock. Software can change the modes at run time. The upstream configuration keeps every mode at zero out of reset, so the whole path starts transparent.

The pin count is a parameter. Pin `p` takes its mode from bits `2p+1:2p` of each mode vector.

Top module: `pin_input_conditioner`

## Requirements
- R1: While `rst_ni` is low, every sampling flop holds 0. A pin whose two modes are both 0 still follows its pad value combinationally during reset.
- R2: With both modes of a pin at 0, `data_o[p]` equals `pad_i[p]` within the same cycle, with no clock edge in between.
- R3: With both modes at 2 (rising edge), a pad change made just after a rising edge appears at `data_o` after exactly the second following rising edge, and not after the first.
- R4: Mode 3 behaves exactly like mode 2 in both stages, with the same two-rising-edge latency.
- R5: With the first-stage mode at 1 (falling edge) and the second-stage mode at 0, a pad change appears at the next falling edge of the clock.
- R6: With the first-stage mode at 1 and the second-stage mode at 2, a pad change made after a rising edge is captured at the next falling edge. It reaches `data_o` at the rising edge after that, and not before.
- R7: With the first-stage mode at 2 and the second-stage mode at 1, a pad change made after a rising edge reaches `data_o` at the falling edge that follows the next rising edge.
- R8: Each pin uses only its own mode bits, `2p+1:2p`. Pins set to different modes at the same time each show their own latency for one common pad transition.
- R9: With the first-stage mode at 0 and the second-stage mode at 2, a pad change appears after exactly one rising edge.
- R10: While `rst_ni` is low, a pin with both stages in a sampling mode (any non-zero mode) drives `data_o[p]` low, whatever the pad value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operating clock; both edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pad_i | input | PINS | Raw pad input values |
| stage1_mode_i | input | 2*PINS | First-stage mode per pin: 0 transparent, 1 falling edge, 2 or 3 rising edge |
| stage2_mode_i | input | 2*PINS | Second-stage mode per pin, with the same encoding |
| data_o | output | PINS | Conditioned input values |

## Verification
Two behaviours can land in the same clock cycle: a transparent lane updating at once, and a registered lane still holding its old value. The bench provokes this by setting the four pins to four different mode pairs and raising all pads in one step. It then samples after that step, after each falling edge and after each rising edge. The expected vector at every sample is derived from each lane's own latency, so a lane that picks up a neighbour's mode bits or the wrong edge gives a mismatched vector.

// File: rtl/pin_sync_pkg.sv
package pin_sync_pkg;

  typedef enum logic [1:0] {
    SYNC_THRU     = 2'd0,
    SYNC_FALL     = 2'd1,
    SYNC_RISE     = 2'd2,
    SYNC_RISE_ALT = 2'd3
  } sync_mode_e;

  localparam int unsigned MODE_W = 2;

  function automatic logic mode_is_rise(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/pin_sync_stage.sv
module pin_sync_stage
  import pin_sync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              d_i,
  output logic              q_o
);

  logic q_rise;
  logic q_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_rise <= 1'b0;
    else         q_rise <= d_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_fall <= 1'b0;
    else         q_fall <= d_i;
  end

  always_comb begin
    unique case (sync_mode_e'(mode_i))
      SYNC_THRU:               q_o = d_i;
      SYNC_FALL:               q_o = q_fall;
      SYNC_RISE, SYNC_RISE_ALT: q_o = q_rise;
      default:                 q_o = d_i;
    endcase
  end

endmodule

// File: rtl/pin_sync_lane.sv
module pin_sync_lane
  import pin_sync_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [STAGES*MODE_W-1:0] mode_i,
  input  logic                     pad_i,
  output logic                     data_o
);

  logic [STAGES:0] chain;

  assign chain[0] = pad_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    pin_sync_stage i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_i[s*MODE_W +: MODE_W]),
      .d_i    (chain[s]),
      .q_o    (chain[s+1])
    );
  end

  assign data_o = chain[STAGES];

endmodule

// File: rtl/pin_input_conditioner.sv
module pin_input_conditioner
  import pin_sync_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PINS-1:0]        pad_i,
  input  logic [PINS*MODE_W-1:0] stage1_mode_i,
  input  logic [PINS*MODE_W-1:0] stage2_mode_i,
  output logic [PINS-1:0]        data_o
);

  localparam int unsigned STAGES = 2;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [STAGES*MODE_W-1:0] lane_mode;
    assign lane_mode = {stage2_mode_i[p*MODE_W +: MODE_W],
                        stage1_mode_i[p*MODE_W +: MODE_W]};

    pin_sync_lane #(.STAGES(STAGES)) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (lane_mode),
      .pad_i  (pad_i[p]),
      .data_o (data_o[p])
    );
  end

endmodule

// File: rtl/pin_input_conditioner_chk.sv
module pin_input_conditioner_chk #(
  parameter int unsigned PINS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [PINS-1:0]      pad_i,
  input logic [PINS*2-1:0]    stage1_mode_i,
  input logic [PINS*2-1:0]    stage2_mode_i,
  input logic [PINS-1:0]      data_o
);

  logic [1:0] rise_cnt;
  logic [1:0] fall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rise_cnt <= '0;
    else if (rise_cnt != 2'd3) rise_cnt <= rise_cnt + 2'd1;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fall_cnt <= '0;
    else if (fall_cnt != 2'd3) fall_cnt <= fall_cnt + 2'd1;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_chk
    logic [1:0] m1;
    logic [1:0] m2;
    assign m1 = stage1_mode_i[2*p +: 2];
    assign m2 = stage2_mode_i[2*p +: 2];

    // R2
    p_thru_follows_pad_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (m1 == 2'd0 && m2 == 2'd0) |-> data_o[p] == pad_i[p]);

    // R3
    p_rise_two_edges_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_cnt >= 2'd2 && m1[1] && m2[1] && $past(m1[1]) && $past(m2[1]))
        |-> data_o[p] == $past(pad_i[p], 2));

    // R5
    p_fall_one_edge_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (fall_cnt >= 2'd1 && m1 == 2'd1 && m2 == 2'd0 && $past(m1) == 2'd1)
        |-> data_o[p] == $past(pad_i[p]));

    // R10
    p_reset_low_r10: assert property (@(posedge clk_i)
      (!rst_ni && m1 != 2'd0 && m2 != 2'd0) |-> data_o[p] == 1'b0);
  end

endmodule

bind pin_input_conditioner pin_input_conditioner_chk #(.PINS(PINS)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pad_i         (pad_i),
  .stage1_mode_i (stage1_mode_i),
  .stage2_mode_i (stage2_mode_i),
  .data_o        (data_o)
);

// File: tb/test_pin_input_conditioner.sv
module test_pin_input_conditioner;

  localparam int CLK_PERIOD = 10;
  localparam int PINS = 4;

  typedef struct {
    logic [PINS-1:0] exp;
    string           tag;
  } item_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic [PINS-1:0]   pad_i = '0;
  logic [PINS*2-1:0] stage1_mode_i = '0;
  logic [PINS*2-1:0] stage2_mode_i = '0;
  logic [PINS-1:0]   data_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t sb_q[$];
  event  chk_ev;

  pin_input_conditioner #(.PINS(PINS)) i_pin_input_conditioner (
    .clk_i, .rst_ni, .pad_i, .stage1_mode_i, .stage2_mode_i, .data_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // monitor: pops the expected value and compares it with the output
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (data_o !== it.exp) begin
          errors++;
          $display("FAIL %s: data_o=%b expected=%b at %0t", it.tag, data_o, it.exp, $time);
        end
      end
    end
  end

  task automatic expect_out(input logic [PINS-1:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic after_rise();
    @(posedge clk_i); #2;
  endtask

  task automatic after_fall();
    @(negedge clk_i); #2;
  endtask

  // sets the modes, parks the pads low, then returns just after a rising edge
  task automatic setup(input logic [PINS*2-1:0] m1, input logic [PINS*2-1:0] m2);
    stage1_mode_i = m1;
    stage2_mode_i = m2;
    pad_i = '0;
    repeat (3) @(posedge clk_i);
    @(posedge clk_i); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    // R10: sampling modes during reset hold the output low
    stage1_mode_i = {PINS{2'd2}};
    stage2_mode_i = {PINS{2'd1}};
    pad_i = 4'b1111;
    #3;
    expect_out(4'b0000, "R10 reset sampling lanes low");
    after_rise();
    expect_out(4'b0000, "R10 reset after clock edge");
    // R1: transparent lanes follow the pad during reset
    stage1_mode_i = '0;
    stage2_mode_i = '0;
    pad_i = 4'b1010;
    #1;
    expect_out(4'b1010, "R1 transparent during reset");
    @(negedge clk_i); #2;
    rst_ni = 1'b1;

    // R2: fully transparent
    pad_i = 4'b0110; #1;
    expect_out(4'b0110, "R2 transparent pattern a");
    pad_i = 4'b1001; #1;
    expect_out(4'b1001, "R2 transparent pattern b");

    // R3: rising/rising, two rising edges
    setup({PINS{2'd2}}, {PINS{2'd2}});
    pad_i = 4'b1111; #1;
    expect_out(4'b0000, "R3 no change before edges");
    after_rise();
    expect_out(4'b0000, "R3 unchanged after first rising edge");
    after_fall();
    expect_out(4'b0000, "R3 unchanged at falling edge");
    after_rise();
    expect_out(4'b1111, "R3 updated after second rising edge");

    // R4: mode 3 same as mode 2
    stage1_mode_i = {PINS{2'd3}};
    stage2_mode_i = {PINS{2'd3}};
    repeat (2) @(posedge clk_i);
    #1;
    pad_i = 4'b0000;
    after_rise();
    expect_out(4'b1111, "R4 unchanged after first rising edge");
    after_rise();
    expect_out(4'b0000, "R4 updated after second rising edge");

    // R5: falling then transparent
    setup({PINS{2'd1}}, {PINS{2'd0}});
    pad_i = 4'b1100; #1;
    expect_out(4'b0000, "R5 unchanged before falling edge");
    after_fall();
    expect_out(4'b1100, "R5 updated at falling edge");

    // R6: falling then rising
    setup({PINS{2'd1}}, {PINS{2'd2}});
    pad_i = 4'b0101;
    after_fall();
    expect_out(4'b0000, "R6 unchanged after falling edge");
    after_rise();
    expect_out(4'b0101, "R6 updated at next rising edge");

    // R7: rising then falling
    setup({PINS{2'd2}}, {PINS{2'd1}});
    pad_i = 4'b0011;
    after_fall();
    expect_out(4'b0000, "R7 unchanged at first falling edge");
    after_rise();
    expect_out(4'b0000, "R7 unchanged after rising edge");
    after_fall();
    expect_out(4'b0011, "R7 updated at following falling edge");

    // R9: transparent then rising
    setup({PINS{2'd0}}, {PINS{2'd2}});
    pad_i = 4'b1011; #1;
    expect_out(4'b0000, "R9 unchanged before rising edge");
    after_rise();
    expect_out(4'b1011, "R9 updated after one rising edge");

    // R8: mixed modes per pin, one common transition
    // pin0 0/0, pin1 1/0, pin2 2/2, pin3 3/1
    setup(8'b11_10_01_00, 8'b01_10_00_00);
    pad_i = 4'b1111; #1;
    expect_out(4'b0001, "R8 mixed immediate");
    after_fall();
    expect_out(4'b0011, "R8 mixed first falling");
    after_rise();
    expect_out(4'b0011, "R8 mixed first rising");
    after_fall();
    expect_out(4'b1011, "R8 mixed second falling");
    after_rise();
    expect_out(4'b1111, "R8 mixed second rising");

    #5;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule